// File: doc/BRIEF.md
# Coherent Multi-Byte Reading Latch

This block keeps 10-bit measurement results readable as bytes without tearing. Each channel's result is exposed as an 8-bit upper register holding bits [9:2]. The two low bits of every channel are packed together into one shared extended register. A host that wants a full-precision value reads the extended register first and then the upper bytes. The block guarantees that the bytes it returns all belong to the same sample, even while the converter keeps delivering new results.

A read of the extended register takes a snapshot. The extended register and every channel's upper register then stay fixed until each upper register has been read once. Converter results that arrive during the snapshot go to per-channel shadow storage, where a later arrival overwrites an earlier one. The clock after the last pending upper byte is read, the shadowed values become visible. Reading an upper register without first reading the extended register returns live data and takes no snapshot.

Top module: `coherent_read_latch`

## Requirements
- R1: A read strobe at address 0x20+i (channel i) returns bits [9:2] of that channel's visible result on rdData, registered, in the cycle after the strobe.
- R2: A read of address 0x10 returns channel i's two low result bits at rdData bits [2i+3:2i+2]: channel 0 in [3:2], channel 1 in [5:4].
- R3: Bits of the extended register that carry no channel field read as 0, as does any address that maps to no register. A cycle without a read strobe also leaves rdData at 0.
- R4: A read of the extended register while no snapshot is active starts a snapshot. From then on, upper-register reads return the values captured at that read.
- R5: A snapshot lasts until every channel's upper register has been read at least once. Extended-register reads during a snapshot return the captured value and do not restart it.
- R6: When no snapshot is active, reading an upper register returns the newest result and starts no snapshot.
- R7: Results that arrive during a snapshot are held per channel, and the newest one wins. They become visible when the snapshot ends.
- R8: The snapshot ends on the clock after the last pending upper byte is read. A read in that cycle already sees the released values, and an extended-register read in that cycle starts a new snapshot over them.
- R9: A result that arrives in the same cycle as a snapshot-starting extended read is not part of the returned value. It is held and shown after that snapshot ends.
- R10: After reset every result reads as 0 and no snapshot is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | NumChan | Per-channel new-result strobe |
| updData | input | NumChan*ResW | New results, channel i at [i*ResW +: ResW] |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | AddrW | Register byte address |
| rdData | output | 8 | Read data, valid the cycle after rdEn |

## Verification
Two events can land in the same cycle: a converter update, and the extended-register read that starts a snapshot. The bench drives both in one cycle. It then expects the old low bits from that read and the old upper byte from the following read, and the new value only after the remaining upper bytes have been read. A second collision puts an extended read in the release cycle itself. There the bench expects the just-released shadow value both in that read and in the new snapshot it starts.

// File: rtl/crl_pkg.sv
package crl_pkg;
  typedef struct packed {
    logic holdNext;
    logic relNow;
  } crlStrobe_t;
endpackage

// File: rtl/crl_ctrl.sv
module crl_ctrl
  import crl_pkg::*;
#(
  parameter int NumChan = 2,
  parameter int AddrW   = 8,
  parameter int ExtAddr = 'h10,
  parameter int MsbBase = 'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic [AddrW-1:0]   rdAddr,
  output crlStrobe_t         strobe,
  output logic               frozen,
  output logic [NumChan-1:0] needMsb
);
  logic [NumChan-1:0] msbHit;
  logic extHit, relNow, freezeStart, holdNext;

  for (genvar g = 0; g < NumChan; g++) begin : gHit
    assign msbHit[g] = rdEn && (rdAddr == AddrW'(MsbBase + g));
  end

  always_comb begin
    extHit      = rdEn && (rdAddr == AddrW'(ExtAddr));
    relNow      = frozen && (needMsb == '0);
    freezeStart = extHit && (!frozen || relNow);
    holdNext    = freezeStart || (frozen && !relNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frozen  <= 1'b0;
      needMsb <= '0;
    end else begin
      frozen <= holdNext;
      if (freezeStart)   needMsb <= '1;
      else if (holdNext) needMsb <= needMsb & ~msbHit;
      else               needMsb <= '0;
    end
  end

  assign strobe.holdNext = holdNext;
  assign strobe.relNow   = relNow;
endmodule

// File: rtl/crl_data.sv
module crl_data
  import crl_pkg::*;
#(
  parameter int NumChan = 2,
  parameter int ResW    = 10,
  parameter int AddrW   = 8,
  parameter int ExtAddr = 'h10,
  parameter int MsbBase = 'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  crlStrobe_t              strobe,
  input  logic [NumChan-1:0]      updValid,
  input  logic [NumChan*ResW-1:0] updData,
  input  logic                    rdEn,
  input  logic [AddrW-1:0]        rdAddr,
  output logic [7:0]              rdData
);
  localparam int LsbW  = ResW - 8;
  localparam int ExtLo = 2;

  logic [NumChan-1:0][ResW-1:0] vis, shadow, srcVal;
  logic [NumChan-1:0] pend;
  logic [7:0] rdNext;

  for (genvar g = 0; g < NumChan; g++) begin : gChan
    logic [ResW-1:0] newVal;
    assign newVal    = updData[g*ResW +: ResW];
    assign srcVal[g] = (strobe.relNow && pend[g]) ? shadow[g] : vis[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vis[g]    <= '0;
        shadow[g] <= '0;
        pend[g]   <= 1'b0;
      end else begin
        vis[g]  <= (!strobe.holdNext && updValid[g]) ? newVal : srcVal[g];
        if (strobe.holdNext && updValid[g]) shadow[g] <= newVal;
        pend[g] <= strobe.holdNext && (updValid[g] || (pend[g] && !strobe.relNow));
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (rdEn) begin
      if (rdAddr == AddrW'(ExtAddr)) begin
        for (int i = 0; i < NumChan; i++)
          rdNext[ExtLo + LsbW*i +: LsbW] = srcVal[i][LsbW-1:0];
      end
      for (int i = 0; i < NumChan; i++)
        if (rdAddr == AddrW'(MsbBase + i)) rdNext = srcVal[i][ResW-1 -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/coherent_read_latch.sv
module coherent_read_latch
  import crl_pkg::*;
#(
  parameter int NumChan = 2,
  parameter int ResW    = 10,
  parameter int AddrW   = 8,
  parameter int ExtAddr = 'h10,
  parameter int MsbBase = 'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumChan-1:0]      updValid,
  input  logic [NumChan*ResW-1:0] updData,
  input  logic                    rdEn,
  input  logic [AddrW-1:0]        rdAddr,
  output logic [7:0]              rdData
);
  crlStrobe_t strobe;
  logic frozen;
  logic [NumChan-1:0] needMsb;

  crl_ctrl #(.NumChan(NumChan), .AddrW(AddrW), .ExtAddr(ExtAddr), .MsbBase(MsbBase)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .strobe(strobe), .frozen(frozen), .needMsb(needMsb)
  );

  crl_data #(.NumChan(NumChan), .ResW(ResW), .AddrW(AddrW), .ExtAddr(ExtAddr), .MsbBase(MsbBase)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .updValid(updValid), .updData(updData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/coherent_read_latch_chk.sv
module coherent_read_latch_chk #(
  parameter int NumChan = 2,
  parameter int ResW    = 10,
  parameter int AddrW   = 8,
  parameter int ExtAddr = 'h10,
  parameter int MsbBase = 'h20
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdEn,
  input logic [AddrW-1:0]   rdAddr,
  input logic [7:0]         rdData,
  input logic               frozen,
  input logic [NumChan-1:0] needMsb
);
  localparam int LsbW = ResW - 8;
  localparam logic [7:0] ExtMask = 8'(((1 << (LsbW*NumChan)) - 1) << 2);

  logic extRd, msbRd;
  assign extRd = rdEn && (rdAddr == AddrW'(ExtAddr));
  assign msbRd = rdEn && (rdAddr >= AddrW'(MsbBase)) && (rdAddr < AddrW'(MsbBase + NumChan));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !extRd && !msbRd |=> rdData == 8'h00); // R3
  AST_EXT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    extRd |=> (rdData & ~ExtMask) == 8'h00); // R2
  AST_FREEZE_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    extRd && (!frozen || needMsb == '0) |=> frozen && (&needMsb)); // R4
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    frozen && needMsb != '0 |=> frozen); // R5
  AST_LIVE_NO_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !frozen && !extRd |=> !frozen); // R6
  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    frozen && needMsb == '0 && !extRd |=> !frozen); // R8
endmodule

bind coherent_read_latch coherent_read_latch_chk #(
  .NumChan(NumChan), .ResW(ResW), .AddrW(AddrW), .ExtAddr(ExtAddr), .MsbBase(MsbBase)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .frozen(frozen), .needMsb(needMsb)
);

// File: tb/coherent_read_latch_bench.sv
module coherent_read_latch_bench;
  localparam logic [7:0] EXT = 8'h10, M0 = 8'h20, M1 = 8'h21;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] updValid = '0;
  logic [19:0] updData = '0;
  logic rdEn = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic chkNext = 1'b0;

  always #2.5 clk = ~clk;

  coherent_read_latch u_coherent_read_latch (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updData(updData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic cyc(input logic doRd, input logic [7:0] addr, input logic [7:0] exp,
                     input string tag, input logic [1:0] um, input logic [9:0] d0,
                     input logic [9:0] d1);
    rdEn = doRd; rdAddr = addr; updValid = um; updData = {d1, d0};
    if (doRd) begin expQ.push_back(exp); tagQ.push_back(tag); end
    @(negedge clk);
    rdEn = 1'b0; updValid = '0;
  endtask
  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    cyc(1'b1, addr, exp, tag, 2'b00, 10'd0, 10'd0);
  endtask
  task automatic up(input logic [1:0] um, input logic [9:0] d0, input logic [9:0] d1);
    cyc(1'b0, 8'h00, 8'h00, "", um, d0, d1);
  endtask
  task automatic idle();
    cyc(1'b0, 8'h00, 8'h00, "", 2'b00, 10'd0, 10'd0);
  endtask

  always @(posedge clk) chkNext <= rdEn && rstN;

  always @(negedge clk) begin
    if (chkNext) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      compared++;
      if (rdData !== e) begin
        mismatched++;
        $display("FAIL %s: got %02h expected %02h", t, rdData, e);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compared++;
    if (rdData !== 8'h00) begin
      mismatched++;
      $display("FAIL R10 reset: got %02h expected 00", rdData);
    end
    rd(EXT, 8'h00, "R10 ext after reset");
    rd(M0, 8'h00, "R10 msb0 after reset");
    rd(M1, 8'h00, "R10 msb1 after reset");
    idle();
    // live reads, no snapshot
    up(2'b11, 10'h2B5, 10'h1FE);
    idle();
    rd(M0, 8'hAD, "R1 msb0");
    rd(M1, 8'h7F, "R1 msb1");
    up(2'b01, 10'h0C3, 10'h000);
    rd(M0, 8'h30, "R6 live msb0 after update");
    // snapshot
    rd(EXT, 8'h2C, "R2 ext fields");
    up(2'b11, 10'h3FF, 10'h001);
    rd(M0, 8'h30, "R4 msb0 frozen");
    rd(EXT, 8'h2C, "R5 ext reread frozen");
    rd(M1, 8'h7F, "R4 msb1 frozen");
    idle();
    rd(M0, 8'hFF, "R7 msb0 released");
    rd(EXT, 8'h1C, "R7 ext released");
    rd(M1, 8'h00, "R7 msb1 released");
    rd(M0, 8'hFF, "R5 msb0 second");
    idle();
    // collision: update with snapshot-starting read
    cyc(1'b1, EXT, 8'h1C, "R9 ext with same-cycle update", 2'b10, 10'h000, 10'h2AA);
    up(2'b10, 10'h000, 10'h155);
    rd(M1, 8'h00, "R9 msb1 still old");
    rd(M0, 8'hFF, "R4 msb0 frozen");
    idle();
    rd(M1, 8'h55, "R7 newest wins");
    // ext read in release cycle
    rd(EXT, 8'h1C, "R2 ext both fields");
    up(2'b01, 10'h100, 10'h000);
    rd(M0, 8'hFF, "R4 msb0 frozen");
    rd(M1, 8'h55, "R4 msb1 frozen");
    rd(EXT, 8'h10, "R8 ext in release cycle");
    rd(M0, 8'h40, "R8 msb0 new snapshot");
    rd(M1, 8'h55, "R8 msb1 new snapshot");
    idle();
    rd(8'h30, 8'h00, "R3 unmapped address");
    rd(8'h22, 8'h00, "R3 address past channels");
    rd(M0, 8'h40, "R6 live msb0");
    repeat (3) idle();
    finishRun();
  end
endmodule